// File: doc/BRIEF.md
# OTP Command and Status Controller

This block is a small register file placed in front of a one-time-programmable word array. Software puts a word address and, for programming, a data word into registers, then writes a 32-bit magic code to the command register. The block latches the code, address and data word, holds its idle flags low for a fixed number of cycles, and then carries out the command against an internal storage model. Results go into two capture registers. Reads of the data region return a pair of words. Reads of the configuration region return one word. A program command can only set bits.

The status register shows the idle state and two sticky error flags. The qualifier register shows two mode fields that are taken from a strap input when reset ends. The storage model keeps 2^STORE_AW words. A legal word address `a` selects cell `a mod 2^STORE_AW`, and the cell after the last one wraps to cell 0. Every cell reads zero after reset.

Top module: `otp_cmd_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, the status register (offset 0x014) reads 0x00000006, every other register reads zero, and every storage cell reads zero.
- R2: The registers at offsets 0x000 (protection), 0x010 (address), 0x020 (capture 1) and 0x024 (capture 2) can be read and written. Any offset without a register reads zero, and writes to such an offset have no effect.
- R3: Bus writes to the status register and to the qualifier register (offset 0x040) are ignored. The command register (offset 0x004) always reads zero.
- R4: The qualifier register reads strap bits 3:2 in bits 13:12 and strap bits 1:0 in bits 11:10, with all other bits zero. The strap is taken at the first clock edge after reset. Later changes to the strap have no effect.
- R5: The codes 0x23B1E361 (read), 0x23B1E362 (mode write) and 0x23B1E364 (program) are recognised. After an accepted command write, status bits 2 and 1 read 0 for exactly CMD_CYCLES cycles and then read 1 again. The command's results appear at the edge where the idle bits return to 1.
- R6: A read at a word address below 0x800 loads cell(a) into capture 1 and cell(a+1) into capture 2.
- R7: A read at a word address from 0x800 to 0xFFF loads cell(a) into capture 1 and leaves capture 2 unchanged.
- R8: A read or program at a word address of 0x1000 or above changes neither the capture registers nor the storage, and sets the sticky reject flag in status bit 5.
- R9: A program at a legal address replaces cell(a) with cell(a) OR the capture 1 value that was latched when the command was written.
- R10: A mode write at address 0, 0x1000, 0x3000 or 0x5000 has no effect. A mode write at any other address sets status bit 5.
- R11: A command word that is not one of the three codes still runs the busy window. It changes no capture register and no storage cell, and it sets status bit 5.
- R12: A command word written while the block is busy is dropped, with no effect on storage, and sets the sticky status bit 4. Both error bits stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_qual_i | input | 4 | Mode fields for the qualifier register, taken when reset ends |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | BUS_AW | Register byte offset |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i (combinational) |

## Verification
The hardest situation to create is a second command word that arrives inside the busy window of the first. To get there, the stimulus writes a harmless mode command and, one cycle later, a program command that would set every bit of cell 0. Reading cell 0 afterwards must show it unchanged. The other difficult area is the edges of the address windows and of the storage index. Random addresses are drawn from bands that straddle 0x800 and 0x1000, and a directed pair read at 0x7FF must show the wrap from the last cell back to cell 0.

// File: rtl/otp_cmd_pkg.sv
package otp_cmd_pkg;
  typedef enum logic [1:0] {OP_READ, OP_MODE, OP_PROG, OP_BAD} otp_op_e;

  localparam logic [31:0] CODE_READ = 32'h23B1_E361;
  localparam logic [31:0] CODE_MODE = 32'h23B1_E362;
  localparam logic [31:0] CODE_PROG = 32'h23B1_E364;

  localparam logic [31:0] MODE_SEL_A = 32'h0000_1000;
  localparam logic [31:0] MODE_SEL_B = 32'h0000_3000;
  localparam logic [31:0] MODE_SEL_C = 32'h0000_5000;

  localparam logic [11:0] OFF_PROT = 12'h000;
  localparam logic [11:0] OFF_CMD  = 12'h004;
  localparam logic [11:0] OFF_ADDR = 12'h010;
  localparam logic [11:0] OFF_STAT = 12'h014;
  localparam logic [11:0] OFF_CAP1 = 12'h020;
  localparam logic [11:0] OFF_CAP2 = 12'h024;
  localparam logic [11:0] OFF_QUAL = 12'h040;

  localparam int ST_MEM_IDLE = 1;
  localparam int ST_CTL_IDLE = 2;
  localparam int ST_ERR_BUSY = 4;
  localparam int ST_ERR_REJ  = 5;
endpackage

// File: rtl/otp_cmd_decode.sv
module otp_cmd_decode
  import otp_cmd_pkg::*;
#(
  parameter int DATA_WORDS  = 2048,
  parameter int TOTAL_WORDS = 4096
) (
  input  logic [31:0] code_i,
  input  logic [31:0] addr_i,
  output otp_op_e     op_o,
  output logic        ok_o,
  output logic        pair_o
);
  localparam logic [31:0] DATA_LIM  = 32'(DATA_WORDS);
  localparam logic [31:0] TOTAL_LIM = 32'(TOTAL_WORDS);

  logic in_range;
  assign in_range = addr_i < TOTAL_LIM;

  always_comb begin
    op_o   = OP_BAD;
    ok_o   = 1'b0;
    pair_o = 1'b0;
    unique case (code_i)
      CODE_READ: begin
        op_o   = OP_READ;
        ok_o   = in_range;
        pair_o = addr_i < DATA_LIM;
      end
      CODE_PROG: begin
        op_o = OP_PROG;
        ok_o = in_range;
      end
      CODE_MODE: begin
        op_o = OP_MODE;
        ok_o = (addr_i == '0) || (addr_i == MODE_SEL_A) ||
               (addr_i == MODE_SEL_B) || (addr_i == MODE_SEL_C);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/otp_cmd_seq.sv
module otp_cmd_seq #(
  parameter int CMD_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (CMD_CYCLES > 1) ? $clog2(CMD_CYCLES) : 1;

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(CMD_CYCLES - 1);
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/otp_word_store.sv
module otp_word_store #(
  parameter int STORE_AW = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [STORE_AW-1:0] idx_i,
  input  logic                prog_i,
  input  logic [31:0]         pdata_i,
  output logic [31:0]         word0_o,
  output logic [31:0]         word1_o
);
  localparam int WORDS = 1 << STORE_AW;

  logic [31:0]         cell_w [WORDS];
  logic [STORE_AW-1:0] idx_nx;

  assign idx_nx = idx_i + 1'b1;  // wraps to cell 0

  for (genvar g = 0; g < WORDS; g++) begin : g_cell
    logic [31:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 q <= '0;
      else if (prog_i && idx_i == STORE_AW'(g))    q <= q | pdata_i;
    end
    assign cell_w[g] = q;
  end

  assign word0_o = cell_w[idx_i];
  assign word1_o = cell_w[idx_nx];
endmodule

// File: rtl/otp_cmd_ctrl.sv
module otp_cmd_ctrl
  import otp_cmd_pkg::*;
#(
  parameter int CMD_CYCLES  = 4,
  parameter int STORE_AW    = 7,
  parameter int DATA_WORDS  = 2048,
  parameter int TOTAL_WORDS = 4096,
  parameter int BUS_AW      = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        strap_qual_i,
  input  logic              wr_en_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);
  logic [31:0] prot_q, addr_q, cap1_q, cap2_q;
  logic [31:0] op_code_q, op_addr_q, op_data_q;
  logic [3:0]  qual_bits_q;
  logic        qual_ld_q, err_busy_q, err_rej_q;

  logic        busy, done, cmd_wr, start, ok, pair, prog_fire;
  otp_op_e     op;
  logic [31:0] word0, word1, status_w, qual_w;

  function automatic logic hit(input logic [BUS_AW-1:0] a, input logic [11:0] off);
    return a == BUS_AW'(off);
  endfunction

  assign cmd_wr = wr_en_i && hit(addr_i, OFF_CMD);
  assign start  = cmd_wr && !busy;

  otp_cmd_seq #(.CMD_CYCLES(CMD_CYCLES)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .busy_o (busy),
    .done_o (done)
  );

  otp_cmd_decode #(.DATA_WORDS(DATA_WORDS), .TOTAL_WORDS(TOTAL_WORDS)) u_dec (
    .code_i(op_code_q),
    .addr_i(op_addr_q),
    .op_o  (op),
    .ok_o  (ok),
    .pair_o(pair)
  );

  assign prog_fire = done && ok && (op == OP_PROG);

  otp_word_store #(.STORE_AW(STORE_AW)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idx_i  (op_addr_q[STORE_AW-1:0]),
    .prog_i (prog_fire),
    .pdata_i(op_data_q),
    .word0_o(word0),
    .word1_o(word1)
  );

  // operands are frozen when the command is accepted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_code_q <= '0;
      op_addr_q <= '0;
      op_data_q <= '0;
    end else if (start) begin
      op_code_q <= wdata_i;
      op_addr_q <= addr_q;
      op_data_q <= cap1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q <= '0;
      addr_q <= '0;
      cap1_q <= '0;
      cap2_q <= '0;
    end else begin
      if (wr_en_i) begin
        if (hit(addr_i, OFF_PROT)) prot_q <= wdata_i;
        if (hit(addr_i, OFF_ADDR)) addr_q <= wdata_i;
        if (hit(addr_i, OFF_CAP1)) cap1_q <= wdata_i;
        if (hit(addr_i, OFF_CAP2)) cap2_q <= wdata_i;
      end
      if (done && ok && op == OP_READ) begin
        cap1_q <= word0;
        if (pair) cap2_q <= word1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_busy_q <= 1'b0;
      err_rej_q  <= 1'b0;
    end else begin
      if (cmd_wr && busy) err_busy_q <= 1'b1;
      if (done && !ok)    err_rej_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qual_ld_q   <= 1'b0;
      qual_bits_q <= '0;
    end else if (!qual_ld_q) begin
      qual_ld_q   <= 1'b1;
      qual_bits_q <= strap_qual_i;
    end
  end

  always_comb begin
    status_w = '0;
    status_w[ST_MEM_IDLE] = !busy;
    status_w[ST_CTL_IDLE] = !busy;
    status_w[ST_ERR_BUSY] = err_busy_q;
    status_w[ST_ERR_REJ]  = err_rej_q;
  end

  assign qual_w = {18'b0, qual_bits_q, 10'b0};

  always_comb begin
    rdata_o = '0;
    if      (hit(addr_i, OFF_PROT)) rdata_o = prot_q;
    else if (hit(addr_i, OFF_ADDR)) rdata_o = addr_q;
    else if (hit(addr_i, OFF_STAT)) rdata_o = status_w;
    else if (hit(addr_i, OFF_CAP1)) rdata_o = cap1_q;
    else if (hit(addr_i, OFF_CAP2)) rdata_o = cap2_q;
    else if (hit(addr_i, OFF_QUAL)) rdata_o = qual_w;
  end
endmodule

// File: rtl/otp_cmd_chk.sv
module otp_cmd_chk #(
  parameter int CMD_CYCLES = 4
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        cmd_wr_i,
  input logic        busy_i,
  input logic        done_i,
  input logic        ok_i,
  input logic        qual_ld_i,
  input logic [31:0] status_i,
  input logic [31:0] cap1_i,
  input logic [31:0] cap2_i,
  input logic [31:0] qual_i
);
  logic [15:0] busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len <= '0;
    else if (busy_i) busy_len <= busy_len + 1'b1;
    else             busy_len <= '0;
  end

  assert_enter_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && !busy_i |=> !status_i[2] && !status_i[1]);

  assert_busy_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> busy_len == 16'(CMD_CYCLES));

  assert_drop_flag_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && busy_i |=> status_i[4]);

  assert_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[4] |=> status_i[4] && status_i[5] == $past(status_i[5]) || status_i[5]);

  assert_reject_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !ok_i && !wr_en_i |=> $stable(cap1_i) && $stable(cap2_i));

  assert_reject_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !ok_i |=> status_i[5]);

  assert_qual_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_ld_i |=> $stable(qual_i));
endmodule

bind otp_cmd_ctrl otp_cmd_chk #(.CMD_CYCLES(CMD_CYCLES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .cmd_wr_i (cmd_wr),
  .busy_i   (busy),
  .done_i   (done),
  .ok_i     (ok),
  .qual_ld_i(qual_ld_q),
  .status_i (status_w),
  .cap1_i   (cap1_q),
  .cap2_i   (cap2_q),
  .qual_i   (qual_w)
);

// File: tb/sim_otp_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_otp_cmd_ctrl;
  localparam int N  = 4;
  localparam int SW = 128;
  localparam logic [31:0] C_RD = 32'h23B1_E361;
  localparam logic [31:0] C_MD = 32'h23B1_E362;
  localparam logic [31:0] C_PG = 32'h23B1_E364;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  strap_qual_i = 4'b1001;
  logic        wr_en_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;

  otp_cmd_ctrl u0 (.*);

  always #4 clk_i = ~clk_i;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  logic [31:0] mem_m [SW];
  logic [31:0] cap1_m = '0, cap2_m = '0;
  bit rej_m = 0, busy_err_m = 0;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      summary();
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] st_idle();
    return 32'h6 | (32'(busy_err_m) << 4) | (32'(rej_m) << 5);
  endfunction

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk_i); wr_en_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_en_i = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i); wr_en_i = 0; addr_i = a; #1 d = rdata_o;
  endtask

  // issues a command and checks the busy window length (R5)
  task automatic run_cmd(logic [31:0] code, logic [31:0] exp_done_st);
    @(negedge clk_i); wr_en_i = 1; addr_i = 12'h004; wdata_i = code;
    @(negedge clk_i); wr_en_i = 0; addr_i = 12'h014;
    #1 chk("R5 busy first", rdata_o & 32'h6, 32'h0);
    for (int i = 1; i < N; i++) begin
      @(negedge clk_i); #1 chk("R5 busy window", rdata_o & 32'h6, 32'h0);
    end
    @(negedge clk_i); #1 chk("R5 idle again", rdata_o, exp_done_st);
  endtask

  function automatic int idx(logic [31:0] a);
    return int'(a % SW);
  endfunction

  task automatic do_read(logic [31:0] a);
    logic [31:0] d;
    wr(12'h010, a);
    if (a < 32'h1000) begin
      cap1_m = mem_m[idx(a)];
      if (a < 32'h800) cap2_m = mem_m[idx(a + 1)];
    end else rej_m = 1;
    run_cmd(C_RD, st_idle());
    rd(12'h020, d);
    chk(a < 32'h800 ? "R6 pair cap1" : (a < 32'h1000 ? "R7 cfg cap1" : "R8 rej cap1"), d, cap1_m);
    rd(12'h024, d);
    chk(a < 32'h800 ? "R6 pair cap2" : (a < 32'h1000 ? "R7 cfg cap2" : "R8 rej cap2"), d, cap2_m);
  endtask

  task automatic do_prog(logic [31:0] a, logic [31:0] v);
    wr(12'h020, v); cap1_m = v;
    wr(12'h010, a);
    if (a < 32'h1000) mem_m[idx(a)] = mem_m[idx(a)] | v;
    else rej_m = 1;
    run_cmd(C_PG, st_idle());
  endtask

  task automatic do_mode(logic [31:0] a);
    wr(12'h010, a);
    if (!(a == 0 || a == 32'h1000 || a == 32'h3000 || a == 32'h5000)) rej_m = 1;
    run_cmd(C_MD, st_idle());
  endtask

  function automatic logic [31:0] pick_addr();
    case ($urandom % 5)
      0: return $urandom_range(0, 32'h7FF);
      1: return $urandom_range(32'h7F0, 32'h80F);
      2: return $urandom_range(32'h800, 32'hFFF);
      3: return $urandom_range(32'hFF0, 32'h100F);
      default: return $urandom;
    endcase
  endfunction

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_0C7A));
    for (int i = 0; i < SW; i++) mem_m[i] = '0;

    // R1 during reset
    #1;
    addr_i = 12'h014; #1 chk("R1 status reset", rdata_o, 32'h6);
    addr_i = 12'h000; #1 chk("R1 prot reset", rdata_o, 0);
    addr_i = 12'h010; #1 chk("R1 addr reset", rdata_o, 0);
    addr_i = 12'h020; #1 chk("R1 cap1 reset", rdata_o, 0);
    addr_i = 12'h024; #1 chk("R1 cap2 reset", rdata_o, 0);
    addr_i = 12'h040; #1 chk("R1 qual reset", rdata_o, 0);
    #20 rst_ni = 1;

    // R4 strap capture
    repeat (2) @(negedge clk_i);
    strap_qual_i = 4'b0110;
    rd(12'h040, d); chk("R4 qual fields", d, 32'h0000_2400);

    // R2 plain registers and unmapped offsets
    wr(12'h000, 32'hA5A5_1234); rd(12'h000, d); chk("R2 prot rw", d, 32'hA5A5_1234);
    wr(12'h024, 32'h0BAD_F00D); rd(12'h024, d); chk("R2 cap2 rw", d, 32'h0BAD_F00D);
    cap2_m = 32'h0BAD_F00D;
    wr(12'h030, 32'hFFFF_FFFF); rd(12'h030, d); chk("R2 unmapped", d, 0);
    rd(12'h000, d); chk("R2 unmapped no side effect", d, 32'hA5A5_1234);

    // R3 read-only registers
    wr(12'h014, 32'hFFFF_FFFF); rd(12'h014, d); chk("R3 status ro", d, 32'h6);
    wr(12'h040, 32'hFFFF_FFFF); rd(12'h040, d); chk("R3 qual ro", d, 32'h0000_2400);
    rd(12'h004, d); chk("R3 cmd reads zero", d, 0);

    // R1 storage blank, R6 pair read
    do_read(32'h10);
    // R9 program OR, boundary pair wrap at 0x7FF
    do_prog(32'h7F, 32'h0000_00F0);
    do_prog(32'h7F, 32'h0F00_0000);
    do_prog(32'h0, 32'h1234_5678);
    do_read(32'h7FF);
    do_read(32'h800);
    do_read(32'hFFF);
    rd(12'h014, d); chk("R10 no reject yet", d, 32'h6);
    // R10 legal mode selects
    do_mode(32'h0); do_mode(32'h1000); do_mode(32'h3000); do_mode(32'h5000);
    rd(12'h014, d); chk("R10 legal modes ok", d, 32'h6);
    do_read(32'h0);
    // R8 out-of-range read/program
    do_read(32'h1000);
    do_prog(32'h1000, 32'hFFFF_FFFF);
    do_read(32'h0);
    // R10 illegal mode select
    do_mode(32'h2000);
    // R11 unknown code
    wr(12'h010, 32'h5);
    run_cmd(32'h23B1_E363, st_idle());
    rd(12'h020, d); chk("R11 cap1 kept", d, cap1_m);
    rd(12'h024, d); chk("R11 cap2 kept", d, cap2_m);

    // R12 command written inside busy window is dropped
    wr(12'h020, 32'hFFFF_FFFF); cap1_m = 32'hFFFF_FFFF;
    wr(12'h010, 32'h0);
    @(negedge clk_i); wr_en_i = 1; addr_i = 12'h004; wdata_i = C_MD;
    @(negedge clk_i); wdata_i = C_PG;
    @(negedge clk_i); wr_en_i = 0;
    repeat (N + 2) @(negedge clk_i);
    busy_err_m = 1;
    rd(12'h014, d); chk("R12 busy drop flag", d, st_idle());
    do_read(32'h0);
    rd(12'h014, d); chk("R12 flags sticky", d, st_idle());

    // random mix
    for (int it = 0; it < 60; it++) begin
      logic [31:0] a;
      a = pick_addr();
      case ($urandom % 4)
        0: do_read(a);
        1: begin do_prog(a, $urandom); if (a < 32'h1000) do_read(a); end
        2: do_mode($urandom % 3 == 0 ? 32'h3000 : a);
        default: begin
          wr(12'h010, a);
          rej_m = 1;
          run_cmd(32'h23B1_0000 | ($urandom % 32'h10000) | 32'h1, st_idle());
        end
      endcase
    end
    rd(12'h040, d); chk("R4 qual unchanged", d, 32'h0000_2400);
    summary();
  end
endmodule